// File: doc/BRIEF.md
# Zero-Run Detector for Stereo Sample Streams

This block watches a pair of audio sample streams, one for the left channel and one for the right, and reports when a channel has carried nothing but zero-valued samples for a long unbroken run. A valid strobe marks each sample slot. Each channel keeps its own run counter. That counter advances only on zero samples that arrive with the strobe, stops at the run threshold, and restarts on any nonzero sample.

Two flag outputs, one per channel, carry the result. An enable bit turns detection on. A mode bit selects either per-channel reporting or a joint report in which both flags show detection only when both channels have completed a zero run. A polarity bit selects whether a detected flag is driven high or low. A hold-in-reset input forces both flags to the detected level and clears the run counters, so downstream muting stays engaged while the datapath is held in reset. The run threshold and the sample width are parameters. The defaults are 8192 samples and 24 bits.

Top module: `zero_run_detector`

## Requirements
- R1: A channel counts as zero-detected once RUN_LEN (default 8192) consecutive valid samples on it are all zero. Its flag reaches the detected level one clock after the strobe carrying the last sample of the run. After RUN_LEN-1 such samples the flag is still idle.
- R2: With `cfg_combined` = 0 (separate mode), `zflag_left` depends only on left samples and `zflag_right` depends only on right samples.
- R3: With `cfg_combined` = 1 (combined mode), both flags show detection only while both channels have completed a zero run. In this mode the two flags are always equal.
- R4: With `cfg_active_low` = 0, the detected level is 1 and the idle level is 0. With `cfg_active_low` = 1, the detected level is 0 and the idle level is 1.
- R5: With `cfg_en` = 0, both flags are 0 one clock later, whatever the data, the polarity and `hold_rst` are. The run counters keep counting.
- R6: While `hold_rst` = 1 and `cfg_en` = 1, both flags sit at the detected level one clock later, and both run counters are cleared. After release, a full new run is needed before detection.
- R7: A valid nonzero sample on a channel restarts that channel's run count. Its flag returns to the idle level one clock after that strobe.
- R8: The run count saturates at RUN_LEN. Any number of further zero samples keeps the detection without wrapping, and after a release a complete new run of RUN_LEN zeros is needed.
- R9: Samples presented while `smp_valid` = 0 neither advance nor restart a run count, whatever their value.
- R10: After `rst_n` is asserted, the counters are zero and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample-slot strobe, one clock per sample |
| smp_left | input | SAMPLE_W | Left-channel sample |
| smp_right | input | SAMPLE_W | Right-channel sample |
| cfg_en | input | 1 | 1 enables detection; 0 holds both flags at 0 |
| cfg_combined | input | 1 | 0 selects separate mode; 1 selects combined mode |
| cfg_active_low | input | 1 | 0 makes detection drive 1; 1 makes detection drive 0 |
| hold_rst | input | 1 | 1 forces the flags to the detected level and clears the counters |
| zflag_left | output | 1 | Left (or joint) zero-run flag |
| zflag_right | output | 1 | Right (or joint) zero-run flag |

## Verification
A run counter that is off by one shows at the flag as detection one strobe early or one strobe late. The bench therefore samples the flags right after strobe RUN_LEN-1 and right after strobe RUN_LEN. A counter that wraps instead of saturating drops the flag a long while after detection, and the extended zero run exposes it. A counter that is not cleared by a nonzero sample or by the hold input shows up as a flag that comes back too early, in fewer than RUN_LEN strobes. Mode and polarity errors show within one clock of a configuration change, because the flag register picks up the new setting on the next edge.

// File: rtl/zrd_pkg.sv
package zrd_pkg;

   typedef enum logic {
      ZRD_SEPARATE = 1'b0,
      ZRD_COMBINED = 1'b1
   } zrd_mode_e;

   localparam int unsigned ZRD_NUM_CH = 2;

endpackage

// File: rtl/zrd_run_counter.sv
module zrd_run_counter #(
   parameter int unsigned SAMPLE_W = 24,
   parameter int unsigned RUN_LEN  = 8192
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clear,
   input  logic                smp_valid,
   input  logic [SAMPLE_W-1:0] smp_data,
   output logic                run_met
);

   localparam int unsigned     CNT_W = $clog2(RUN_LEN + 1);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RUN_LEN);

   generate
      if (RUN_LEN < 2) begin : g_bad_len
         $error("zrd_run_counter: RUN_LEN must be at least 2");
      end
      if (SAMPLE_W < 1) begin : g_bad_width
         $error("zrd_run_counter: SAMPLE_W must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] run_cnt;
   logic             smp_nonzero;

   assign smp_nonzero = |smp_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt <= '0;
      end else if (clear) begin
         run_cnt <= '0;
      end else if (smp_valid) begin
         if (smp_nonzero) begin
            run_cnt <= '0;
         end else if (run_cnt != LIMIT) begin
            run_cnt <= run_cnt + 1'b1;
         end
      end
   end

   assign run_met = (run_cnt == LIMIT);

   AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
      run_cnt <= LIMIT); // R8

   AST_NONZERO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && smp_nonzero) |=> (run_cnt == '0)); // R7

   AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (!smp_valid && !clear) |=> $stable(run_cnt)); // R9

   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (run_cnt == '0)); // R6

endmodule

// File: rtl/zrd_flag_shaper.sv
module zrd_flag_shaper
   import zrd_pkg::*;
#(
   parameter int unsigned NUM_CH = ZRD_NUM_CH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] run_met,
   input  logic              cfg_en,
   input  zrd_mode_e         cfg_mode,
   input  logic              cfg_active_low,
   input  logic              hold_rst,
   output logic [NUM_CH-1:0] flag
);

   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("zrd_flag_shaper: NUM_CH must be at least 1");
      end
   endgenerate

   logic              all_met;
   logic [NUM_CH-1:0] hit;
   logic [NUM_CH-1:0] flag_d;

   assign all_met = &run_met;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      always_comb begin
         if (hold_rst) begin
            hit[c] = 1'b1;
         end else if (cfg_mode == ZRD_COMBINED) begin
            hit[c] = all_met;
         end else begin
            hit[c] = run_met[c];
         end
         flag_d[c] = cfg_en & (hit[c] ^ cfg_active_low);
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flag[c] <= 1'b0;
         end else begin
            flag[c] <= flag_d[c];
         end
      end
   end

endmodule

// File: rtl/zero_run_detector.sv
module zero_run_detector
   import zrd_pkg::*;
#(
   parameter int unsigned SAMPLE_W = 24,
   parameter int unsigned RUN_LEN  = 8192
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                smp_valid,
   input  logic [SAMPLE_W-1:0] smp_left,
   input  logic [SAMPLE_W-1:0] smp_right,
   input  logic                cfg_en,
   input  logic                cfg_combined,
   input  logic                cfg_active_low,
   input  logic                hold_rst,
   output logic                zflag_left,
   output logic                zflag_right
);

   localparam int unsigned NCH    = ZRD_NUM_CH;
   localparam int unsigned CH_L   = 0;
   localparam int unsigned CH_R   = 1;

   logic [NCH-1:0][SAMPLE_W-1:0] ch_data;
   logic [NCH-1:0]               ch_met;
   logic [NCH-1:0]               ch_flag;

   assign ch_data[CH_L] = smp_left;
   assign ch_data[CH_R] = smp_right;

   for (genvar c = 0; c < NCH; c++) begin : g_cnt
      zrd_run_counter #(
         .SAMPLE_W (SAMPLE_W),
         .RUN_LEN  (RUN_LEN)
      ) u_cnt (
         .clk       (clk),
         .rst_n     (rst_n),
         .clear     (hold_rst),
         .smp_valid (smp_valid),
         .smp_data  (ch_data[c]),
         .run_met   (ch_met[c])
      );
   end

   zrd_flag_shaper #(
      .NUM_CH (NCH)
   ) u_shaper (
      .clk            (clk),
      .rst_n          (rst_n),
      .run_met        (ch_met),
      .cfg_en         (cfg_en),
      .cfg_mode       (zrd_mode_e'(cfg_combined)),
      .cfg_active_low (cfg_active_low),
      .hold_rst       (hold_rst),
      .flag           (ch_flag)
   );

   assign zflag_left  = ch_flag[CH_L];
   assign zflag_right = ch_flag[CH_R];

   AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en |=> (!zflag_left && !zflag_right)); // R5

   AST_HOLD_DETECTED: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_en && hold_rst) |=>
         ((zflag_left == !$past(cfg_active_low)) &&
          (zflag_right == !$past(cfg_active_low)))); // R6

   AST_COMBINED_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_combined |=> (zflag_left == zflag_right)); // R3

   AST_RELEASE_BOTH_NZ: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && (|smp_left) && (|smp_right) && cfg_en && !hold_rst)
         ##1 (cfg_en && !hold_rst)
         |=> ((zflag_left == $past(cfg_active_low)) &&
              (zflag_right == $past(cfg_active_low)))); // R7

endmodule

// File: tb/zero_run_detector_bench.sv
module zero_run_detector_bench;

   localparam int unsigned SAMPLE_W = 24;
   localparam int unsigned RUN_LEN  = 8192;
   localparam int unsigned WDOG     = 200000;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                smp_valid = 1'b0;
   logic [SAMPLE_W-1:0] smp_left = '0;
   logic [SAMPLE_W-1:0] smp_right = '0;
   logic                cfg_en = 1'b0;
   logic                cfg_combined = 1'b0;
   logic                cfg_active_low = 1'b0;
   logic                hold_rst = 1'b0;
   logic                zflag_left;
   logic                zflag_right;

   int  n_checks = 0;
   int  n_fails  = 0;
   bit  done     = 1'b0;

   always #2.5 clk = ~clk;

   zero_run_detector #(
      .SAMPLE_W (SAMPLE_W),
      .RUN_LEN  (RUN_LEN)
   ) u_zero_run_detector (
      .clk            (clk),
      .rst_n          (rst_n),
      .smp_valid      (smp_valid),
      .smp_left       (smp_left),
      .smp_right      (smp_right),
      .cfg_en         (cfg_en),
      .cfg_combined   (cfg_combined),
      .cfg_active_low (cfg_active_low),
      .hold_rst       (hold_rst),
      .zflag_left     (zflag_left),
      .zflag_right    (zflag_right)
   );

   task automatic check_flags(input string req, input logic [1:0] exp);
      logic [1:0] act;
      act = {zflag_left, zflag_right};
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: flags {left,right} actual %b expected %b at %0t",
                  req, act, exp, $time);
      end
   endtask

   task automatic settle();
      @(negedge clk);
   endtask

   task automatic feed(input int n, input logic [SAMPLE_W-1:0] l,
                       input logic [SAMPLE_W-1:0] r);
      @(negedge clk);
      smp_valid = 1'b1;
      smp_left  = l;
      smp_right = r;
      repeat (n) @(negedge clk);
      smp_valid = 1'b0;
      smp_left  = '0;
      smp_right = '0;
   endtask

   task automatic do_reset(input logic en, input logic comb, input logic pol);
      @(negedge clk);
      rst_n = 1'b0;
      cfg_en = en;
      cfg_combined = comb;
      cfg_active_low = pol;
      hold_rst = 1'b0;
      smp_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      settle();
   endtask

   task automatic t_reset_state();
      do_reset(1'b0, 1'b0, 1'b0);
      check_flags("R10 reset state", 2'b00);
   endtask

   task automatic t_separate_threshold();
      do_reset(1'b1, 1'b0, 1'b0);
      check_flags("R10 idle after reset enabled", 2'b00);
      feed(RUN_LEN - 1, '0, 24'h5);
      settle();
      check_flags("R1 one short of threshold", 2'b00);
      feed(1, '0, 24'h5);
      settle();
      check_flags("R1 R2 left detected right not", 2'b10);
   endtask

   task automatic t_saturate_release();
      feed(300, '0, 24'h5);
      settle();
      check_flags("R8 saturated keeps detection", 2'b10);
      feed(1, 24'h7, 24'h5);
      settle();
      check_flags("R7 nonzero releases left", 2'b00);
      feed(RUN_LEN - 1, '0, '0);
      settle();
      check_flags("R8 full new run needed", 2'b00);
      feed(1, '0, '0);
      settle();
      check_flags("R2 both detected separately", 2'b11);
   endtask

   task automatic t_valid_gating();
      do_reset(1'b1, 1'b0, 1'b0);
      feed(RUN_LEN - 1, '0, '0);
      @(negedge clk);
      smp_left  = 24'h9;
      smp_right = 24'h800000;
      repeat (20) @(negedge clk);
      check_flags("R9 unstrobed nonzero ignored", 2'b00);
      smp_left  = '0;
      smp_right = '0;
      feed(1, '0, '0);
      settle();
      check_flags("R9 run survived unstrobed data", 2'b11);
   endtask

   task automatic t_combined();
      do_reset(1'b1, 1'b1, 1'b0);
      feed(RUN_LEN, '0, 24'h3);
      settle();
      check_flags("R3 one channel met only", 2'b00);
      feed(RUN_LEN - 1, '0, '0);
      settle();
      check_flags("R3 right one short", 2'b00);
      feed(1, '0, '0);
      settle();
      check_flags("R3 both met", 2'b11);
      feed(1, '0, 24'h4);
      settle();
      check_flags("R3 R7 combined release", 2'b00);
   endtask

   task automatic t_polarity_enable_hold();
      do_reset(1'b1, 1'b0, 1'b1);
      settle();
      check_flags("R4 active-low idle", 2'b11);
      feed(RUN_LEN, '0, 24'h1);
      settle();
      check_flags("R4 active-low detection", 2'b01);
      cfg_en = 1'b0;
      settle();
      check_flags("R5 disabled low", 2'b00);
      cfg_en = 1'b1;
      settle();
      check_flags("R5 counts kept while disabled", 2'b01);
      hold_rst = 1'b1;
      settle();
      check_flags("R6 hold active-low", 2'b00);
      cfg_active_low = 1'b0;
      settle();
      check_flags("R6 hold active-high", 2'b11);
      cfg_en = 1'b0;
      settle();
      check_flags("R5 disable wins over hold", 2'b00);
      cfg_en = 1'b1;
      hold_rst = 1'b0;
      settle();
      check_flags("R6 counters cleared by hold", 2'b00);
   endtask

   initial begin
      t_reset_state();
      t_separate_threshold();
      t_saturate_release();
      t_valid_gating();
      t_combined();
      t_polarity_enable_hold();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (WDOG) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: run did not complete, actual running expected done");
         $display("End of test - %0d assertions evaluated, %0d failures",
                  n_checks, n_fails);
         $finish;
      end
   end

endmodule